// File: doc/BRIEF.md
# DMA Cache-Line Burst Splitter

This block accepts one DMA transfer at a time and turns it into a series of single cache-line memory requests. A transfer is given by a byte start address, a byte length and an operation code (load or store). The first request may begin partway into a line and may be shorter than a line. Every later request begins on a line boundary and carries up to one full line. A request is issued only after the memory side has answered the one before it. A store is answered with an acknowledge and a load with a line of data.

Store data is taken from a local transfer buffer, which the client fills through a byte-wide host port while the block is idle. Each request places this data on the byte lanes that match its position in the line. Load data returned by memory is unpacked from its lanes into the same buffer, and the client reads it back through the host port. Each accepted transfer is given an ID. The ID is shown when the transfer is accepted and returned with a single-cycle completion pulse.

Top module: `dma_line_splitter`

## Requirements
- R1: `cmd_ready` is high exactly when no transfer is active. It goes low in the cycle after a legal command is accepted and returns high in the same cycle that `done_valid` pulses.
- R2: Operation code 2'b01 is a load and 2'b10 is a store. A command with any other code, with length zero or with length above MAX_BYTES is consumed but not started: `cmd_err` pulses in the next cycle, `cmd_ready` stays high, no request is issued and no ID is used.
- R3: The first request of a transfer has `req_line_addr` = start address with the low log2(LINE_BYTES) bits cleared, and `req_offset` = start address mod LINE_BYTES. Its `req_len` is min(total length, LINE_BYTES - offset).
- R4: Every later request has `req_offset` = 0 and `req_line_addr` = start address + bytes completed, which is line-aligned. Its `req_len` is min(remaining bytes, LINE_BYTES).
- R5: For a store, byte lane `req_offset`+k of `req_wdata` (bits 8*lane+7..8*lane) carries buffer byte (bytes completed + k) for k < `req_len`. All other lanes are zero, and all lanes are zero for a load. `req_write` is 1 for stores and 0 for loads.
- R6: For a load, lane `req_offset`+k of `rsp_data` is written to buffer byte (bytes completed + k) for k < `req_len`. The host port reads buffer byte `hb_addr` with one cycle of latency.
- R7: At most one request is outstanding. After a request handshake, `req_valid` stays low until the matching response is taken. While `req_valid` waits for `req_ready`, the request fields hold steady.
- R8: `cmd_id` shows the ID that the next accepted command receives. IDs increase by one per accepted command and wrap. `done_id` returns the ID of the finished transfer.
- R9: `done_valid` is a one-cycle pulse in the cycle after the response that brings bytes completed up to the total length.
- R10: A response arriving while no request is outstanding raises a one-cycle `rsp_err`. So does a response of the wrong kind (data during a store, acknowledge during a load). Either response is ignored: no progress and no completion.
- R11: Host-port writes while a transfer is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_addr | input | ADDR_W | Byte start address |
| cmd_len | input | LEN_W | Byte length |
| cmd_op | input | 2 | 01 load, 10 store |
| cmd_id | output | ID_W | ID for the next accepted command |
| cmd_err | output | 1 | Illegal command refused (pulse) |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request taken |
| req_line_addr | output | ADDR_W | Line-aligned address |
| req_offset | output | OFF_W | First byte lane within the line |
| req_len | output | CL_W | Byte count of the request |
| req_write | output | 1 | Store request |
| req_wdata | output | LINE_BYTES*8 | Store data on byte lanes |
| rsp_valid | input | 1 | Memory response |
| rsp_is_data | input | 1 | 1 data line, 0 acknowledge |
| rsp_data | input | LINE_BYTES*8 | Returned line |
| done_valid | output | 1 | Transfer complete (pulse) |
| done_id | output | ID_W | ID of the completed transfer |
| rsp_err | output | 1 | Unexpected response (pulse) |
| hb_we | input | 1 | Host buffer write |
| hb_addr | input | BA_W | Host buffer byte index |
| hb_wdata | input | 8 | Host buffer write byte |
| hb_rdata | output | 8 | Host buffer read byte |

## Verification
The hardest situation to reach is a response of the wrong kind, or a response that arrives with no request outstanding. A well-behaved memory model never produces either. The bench therefore switches off its automatic responder, answers a store by hand with a data line, and then confirms that the transfer neither advances nor completes until a proper acknowledge follows. Unaligned starts that span several lines, and a host write made during a multi-line store, are also driven. Both show whether lane placement and the ignoring of host writes hold for the later chunks.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_ISSUE,
    ST_WAIT
  } state_e;
endpackage

// File: rtl/dls_chunk_calc.sv
module dls_chunk_calc #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 9,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0]                   start_addr,
  input  logic [LEN_W-1:0]                    total_len,
  input  logic [LEN_W-1:0]                    done_len,
  output logic [ADDR_W-1:0]                   chunk_addr,
  output logic [$clog2(LINE_BYTES)-1:0]       chunk_off,
  output logic [$clog2(LINE_BYTES+1)-1:0]     chunk_len
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CL_W  = $clog2(LINE_BYTES + 1);

  logic              first;
  logic [OFF_W-1:0]  soff;
  logic [CL_W-1:0]   room;
  logic [LEN_W-1:0]  remain;

  assign first      = (done_len == '0);
  assign soff       = start_addr[OFF_W-1:0];
  assign room       = first ? (CL_W'(LINE_BYTES) - CL_W'(soff)) : CL_W'(LINE_BYTES);
  assign remain     = total_len - done_len;
  assign chunk_len  = (remain < LEN_W'(room)) ? CL_W'(remain) : room;
  assign chunk_off  = first ? soff : '0;
  assign chunk_addr = start_addr + ADDR_W'(done_len);
endmodule

// File: rtl/dls_line_buf.sv
module dls_line_buf #(
  parameter int MAX_BYTES  = 256,
  parameter int LINE_BYTES = 64
) (
  input  logic                                  clk,
  input  logic                                  host_we,
  input  logic [$clog2(MAX_BYTES)-1:0]          host_addr,
  input  logic [7:0]                            host_wdata,
  output logic [7:0]                            host_rdata,
  input  logic [$clog2(MAX_BYTES+1)-1:0]        g_base,
  input  logic [$clog2(LINE_BYTES)-1:0]         g_off,
  input  logic [$clog2(LINE_BYTES+1)-1:0]       g_len,
  output logic [LINE_BYTES*8-1:0]               g_line,
  input  logic                                  s_en,
  input  logic [$clog2(MAX_BYTES+1)-1:0]        s_base,
  input  logic [$clog2(LINE_BYTES)-1:0]         s_off,
  input  logic [$clog2(LINE_BYTES+1)-1:0]       s_len,
  input  logic [LINE_BYTES*8-1:0]               s_line
);
  localparam int BA_W  = $clog2(MAX_BYTES);
  localparam int LEN_W = $clog2(MAX_BYTES + 1);
  localparam int CL_W  = $clog2(LINE_BYTES + 1);

  logic [7:0] mem [MAX_BYTES];

  // Gather: one lane per line byte, reading the buffer shifted by the lane offset
  for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
    logic             hit;
    logic [LEN_W:0]   src;
    assign hit = (CL_W'(k) >= CL_W'(g_off)) && (CL_W'(k) < (CL_W'(g_off) + g_len));
    assign src = {1'b0, g_base} + (LEN_W+1)'(k) - (LEN_W+1)'(g_off);
    assign g_line[k*8 +: 8] = hit ? mem[src[BA_W-1:0]] : 8'h00;
  end

  // Scatter of returned load data, host write and registered host read
  always_ff @(posedge clk) begin
    if (host_we) begin
      mem[host_addr] <= host_wdata;
    end
    if (s_en) begin
      for (int j = 0; j < LINE_BYTES; j++) begin
        if (CL_W'(j) < s_len) begin
          mem[BA_W'({1'b0, s_base} + (LEN_W+1)'(j))] <= s_line[(int'(s_off) + j)*8 +: 8];
        end
      end
    end
    host_rdata <= mem[host_addr];
  end
endmodule

// File: rtl/dls_ctrl.sv
module dls_ctrl
  import dls_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 9,
  parameter int MAX_BYTES  = 256,
  parameter int LINE_BYTES = 64,
  parameter int ID_W       = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cmd_valid,
  output logic                              cmd_ready,
  input  logic [ADDR_W-1:0]                 cmd_addr,
  input  logic [LEN_W-1:0]                  cmd_len,
  input  logic [1:0]                        cmd_op,
  output logic [ID_W-1:0]                   cmd_id,
  output logic                              cmd_err,
  output logic                              req_valid,
  input  logic                              req_ready,
  output logic [ADDR_W-1:0]                 req_line_addr,
  output logic [$clog2(LINE_BYTES)-1:0]     req_offset,
  output logic [$clog2(LINE_BYTES+1)-1:0]   req_len,
  output logic                              req_write,
  output logic [LINE_BYTES*8-1:0]           req_wdata,
  input  logic                              rsp_valid,
  input  logic                              rsp_is_data,
  output logic                              done_valid,
  output logic [ID_W-1:0]                   done_id,
  output logic                              rsp_err,
  output logic [ADDR_W-1:0]                 start_addr,
  output logic [LEN_W-1:0]                  total_len,
  output logic [LEN_W-1:0]                  done_len,
  input  logic [ADDR_W-1:0]                 chunk_addr,
  input  logic [$clog2(LINE_BYTES)-1:0]     chunk_off,
  input  logic [$clog2(LINE_BYTES+1)-1:0]   chunk_len,
  input  logic [LINE_BYTES*8-1:0]           gather_line,
  output logic                              scat_en,
  output logic                              idle
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CL_W  = $clog2(LINE_BYTES + 1);

  state_e            state;
  logic [ID_W-1:0]   next_id;
  logic [ID_W-1:0]   id_q;
  logic              write_q;
  logic [LEN_W-1:0]  issued_q;
  logic              legal;
  logic              kind_ok;
  op_e               op;

  assign op        = op_e'(cmd_op);
  assign legal     = ((op == OP_LOAD) || (op == OP_STORE)) &&
                     (cmd_len != '0) && (cmd_len <= LEN_W'(MAX_BYTES));
  assign kind_ok   = (rsp_is_data == !write_q);
  assign cmd_ready = (state == ST_IDLE);
  assign idle      = (state == ST_IDLE);
  assign cmd_id    = next_id;
  assign scat_en   = (state == ST_WAIT) && rsp_valid && rsp_is_data && !write_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      next_id       <= '0;
      id_q          <= '0;
      write_q       <= 1'b0;
      start_addr    <= '0;
      total_len     <= '0;
      done_len      <= '0;
      issued_q      <= '0;
      req_valid     <= 1'b0;
      req_line_addr <= '0;
      req_offset    <= '0;
      req_len       <= '0;
      req_write     <= 1'b0;
      req_wdata     <= '0;
      done_valid    <= 1'b0;
      done_id       <= '0;
      cmd_err       <= 1'b0;
      rsp_err       <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      cmd_err    <= 1'b0;
      rsp_err    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (legal) begin
              start_addr <= cmd_addr;
              total_len  <= cmd_len;
              write_q    <= (op == OP_STORE);
              done_len   <= '0;
              issued_q   <= '0;
              id_q       <= next_id;
              next_id    <= next_id + 1'b1;
              state      <= ST_PREP;
            end else begin
              cmd_err <= 1'b1;
            end
          end
        end
        ST_PREP: begin
          req_line_addr <= {chunk_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
          req_offset    <= chunk_off;
          req_len       <= chunk_len;
          req_write     <= write_q;
          req_wdata     <= write_q ? gather_line : '0;
          issued_q      <= done_len + LEN_W'(chunk_len);
          req_valid     <= 1'b1;
          state         <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (!kind_ok) begin
              rsp_err <= 1'b1;
            end else begin
              done_len <= issued_q;
              if (issued_q == total_len) begin
                done_valid <= 1'b1;
                done_id    <= id_q;
                state      <= ST_IDLE;
              end else begin
                state <= ST_PREP;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (rsp_valid && (state != ST_WAIT)) begin
        rsp_err <= 1'b1;
      end
    end
  end

  // Checks beside the control logic
  assert_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && legal) |=> !cmd_ready);
  assert_refuse_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && !legal) |=> (cmd_ready && cmd_err));
  assert_fit_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ((req_len != '0) && ((CL_W'(req_offset) + req_len) <= CL_W'(LINE_BYTES))));
  assert_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_PREP) && (done_len != '0)) |->
      ((chunk_addr[OFF_W-1:0] == '0) && (chunk_off == '0)));
  assert_one_out_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_line_addr) && $stable(req_len)));
  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);
  assert_stray_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (state != ST_WAIT)) |=> rsp_err);
  assert_wrong_kind_R10: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_WAIT) && rsp_valid && !kind_ok) |=>
      ((state == ST_WAIT) && $stable(done_len) && !done_valid));
endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter #(
  parameter int ADDR_W     = 32,
  parameter int MAX_BYTES  = 256,
  parameter int LINE_BYTES = 64,
  parameter int ID_W       = 8,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int BA_W      = $clog2(MAX_BYTES),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CL_W      = $clog2(LINE_BYTES + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [ADDR_W-1:0]         cmd_addr,
  input  logic [LEN_W-1:0]          cmd_len,
  input  logic [1:0]                cmd_op,
  output logic [ID_W-1:0]           cmd_id,
  output logic                      cmd_err,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [ADDR_W-1:0]         req_line_addr,
  output logic [OFF_W-1:0]          req_offset,
  output logic [CL_W-1:0]           req_len,
  output logic                      req_write,
  output logic [LINE_BYTES*8-1:0]   req_wdata,
  input  logic                      rsp_valid,
  input  logic                      rsp_is_data,
  input  logic [LINE_BYTES*8-1:0]   rsp_data,
  output logic                      done_valid,
  output logic [ID_W-1:0]           done_id,
  output logic                      rsp_err,
  input  logic                      hb_we,
  input  logic [BA_W-1:0]           hb_addr,
  input  logic [7:0]                hb_wdata,
  output logic [7:0]                hb_rdata
);
  logic [ADDR_W-1:0]        start_addr;
  logic [LEN_W-1:0]         total_len;
  logic [LEN_W-1:0]         done_len;
  logic [ADDR_W-1:0]        chunk_addr;
  logic [OFF_W-1:0]         chunk_off;
  logic [CL_W-1:0]          chunk_len;
  logic [LINE_BYTES*8-1:0]  gather_line;
  logic                     scat_en;
  logic                     idle;

  dls_chunk_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES)
  ) u_calc (
    .start_addr(start_addr), .total_len(total_len), .done_len(done_len),
    .chunk_addr(chunk_addr), .chunk_off(chunk_off), .chunk_len(chunk_len)
  );

  dls_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES),
    .LINE_BYTES(LINE_BYTES), .ID_W(ID_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_err(cmd_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_line_addr(req_line_addr),
    .req_offset(req_offset), .req_len(req_len), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_is_data(rsp_is_data),
    .done_valid(done_valid), .done_id(done_id), .rsp_err(rsp_err),
    .start_addr(start_addr), .total_len(total_len), .done_len(done_len),
    .chunk_addr(chunk_addr), .chunk_off(chunk_off), .chunk_len(chunk_len),
    .gather_line(gather_line), .scat_en(scat_en), .idle(idle)
  );

  dls_line_buf #(
    .MAX_BYTES(MAX_BYTES), .LINE_BYTES(LINE_BYTES)
  ) u_buf (
    .clk(clk),
    .host_we(hb_we && idle), .host_addr(hb_addr), .host_wdata(hb_wdata),
    .host_rdata(hb_rdata),
    .g_base(done_len), .g_off(chunk_off), .g_len(chunk_len), .g_line(gather_line),
    .s_en(scat_en), .s_base(done_len), .s_off(req_offset), .s_len(req_len),
    .s_line(rsp_data)
  );
endmodule

// File: tb/tb_dma_line_splitter.sv
`timescale 1ns/1ps
module tb_dma_line_splitter;
  localparam int LB = 64;

  logic         clk = 1'b0;
  logic         rst;
  logic         cmd_valid, cmd_ready, cmd_err;
  logic [31:0]  cmd_addr;
  logic [8:0]   cmd_len;
  logic [1:0]   cmd_op;
  logic [7:0]   cmd_id;
  logic         req_valid, req_ready, req_write;
  logic [31:0]  req_line_addr;
  logic [5:0]   req_offset;
  logic [6:0]   req_len;
  logic [511:0] req_wdata;
  logic         rsp_valid, rsp_is_data;
  logic [511:0] rsp_data;
  logic         done_valid, rsp_err;
  logic [7:0]   done_id;
  logic         hb_we;
  logic [7:0]   hb_addr, hb_wdata, hb_rdata;

  always #4 clk = ~clk;

  dma_line_splitter dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_op(cmd_op), .cmd_id(cmd_id),
    .cmd_err(cmd_err), .req_valid(req_valid), .req_ready(req_ready),
    .req_line_addr(req_line_addr), .req_offset(req_offset), .req_len(req_len),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_is_data(rsp_is_data), .rsp_data(rsp_data), .done_valid(done_valid),
    .done_id(done_id), .rsp_err(rsp_err), .hb_we(hb_we), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata)
  );

  typedef struct {
    logic [31:0] line;
    int          off;
    int          len;
    bit          wr;
    int          base;
  } chunk_t;

  chunk_t      exp_q[$];
  logic [7:0]  id_q[$];
  int          checks = 0;
  int          errors = 0;
  int          wseed  = 0;
  bit          auto_mem = 1'b1;
  logic [7:0]  exp_id = 8'd0;

  function automatic logic [7:0] g(int j);
    return 8'((j * 7 + wseed) & 255);
  endfunction

  function automatic logic [7:0] f(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Driver: offers a command and pushes the expected chunks to the scoreboard
  task automatic run_xfer(input logic [31:0] a, input int n, input bit wr, input bit track);
    int done;
    int o;
    int c;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_len = 9'(n); cmd_op = wr ? 2'b10 : 2'b01;
    chk(cmd_id == exp_id, "R8", "accept id", cmd_id, exp_id);
    done = 0;
    while (track && done < n) begin
      o = (done == 0) ? int'(a % LB) : 0;
      c = ((n - done) < (LB - o)) ? (n - done) : (LB - o);
      exp_q.push_back('{line: (a + 32'(done)) & ~32'(LB - 1), off: o, len: c, wr: wr, base: done});
      done += c;
    end
    id_q.push_back(exp_id);
    exp_id++;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R1", "ready low while busy", cmd_ready, 0);
  endtask

  task automatic wait_idle();
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic fill(input int seed);
    wseed = seed;
    for (int j = 0; j < 256; j++) begin
      @(negedge clk);
      hb_we = 1'b1; hb_addr = 8'(j); hb_wdata = g(j);
    end
    @(negedge clk);
    hb_we = 1'b0;
  endtask

  task automatic check_load(input logic [31:0] a, input int n);
    for (int j = 0; j < n; j++) begin
      hb_addr = 8'(j);
      @(negedge clk);
      chk(hb_rdata == f(a + 32'(j)), "R6", "load byte", hb_rdata, f(a + 32'(j)));
    end
  endtask

  task automatic bad_cmd(input logic [1:0] op, input int n);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = 32'h700; cmd_len = 9'(n); cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_err == 1'b1, "R2", "cmd_err pulse", cmd_err, 1);
    chk(cmd_ready == 1'b1, "R2", "ready kept", cmd_ready, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req_valid, "R2", "no request", req_valid, 0);
    end
  endtask

  // Monitor and memory model: pops expected chunks and answers each request
  initial begin
    int lat = 0;
    chunk_t it;
    logic [511:0] ew;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_is_data = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      if (auto_mem && req_valid && !rst) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected request", req_line_addr, 0);
        end else begin
          it = exp_q.pop_front();
          ew = '0;
          if (it.wr) for (int k = 0; k < it.len; k++) ew[(it.off + k)*8 +: 8] = g(it.base + k);
          chk(req_line_addr == it.line, (it.base == 0) ? "R3" : "R4", "line addr", req_line_addr, it.line);
          chk(int'(req_offset) == it.off, (it.base == 0) ? "R3" : "R4", "offset", req_offset, it.off);
          chk(int'(req_len) == it.len, (it.base == 0) ? "R3" : "R4", "length", req_len, it.len);
          chk(req_write == it.wr, "R5", "write flag", req_write, it.wr);
          chk(req_wdata == ew, "R5", "lane data", req_wdata, ew);
          req_ready = 1'b1;
          @(negedge clk);
          req_ready = 1'b0;
          lat = 1 + (lat % 3);
          for (int d = 0; d < lat; d++) begin
            chk(!req_valid, "R7", "no second request", req_valid, 0);
            @(negedge clk);
          end
          rsp_valid = 1'b1;
          rsp_is_data = !it.wr;
          for (int b = 0; b < LB; b++) rsp_data[b*8 +: 8] = it.wr ? 8'h00 : f(it.line + 32'(b));
          @(negedge clk);
          rsp_valid = 1'b0;
        end
      end
    end
  end

  // Completion monitor
  initial begin
    bit prev = 1'b0;
    logic [7:0] e;
    forever begin
      @(negedge clk);
      if (!rst && done_valid) begin
        chk(!prev, "R9", "single pulse", prev, 0);
        chk(cmd_ready, "R1", "ready with completion", cmd_ready, 1);
        if (id_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected completion", done_id, 0);
        end else begin
          e = id_q.pop_front();
          chk(done_id == e, "R8", "done id", done_id, e);
        end
      end
      prev = done_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_addr = '0; cmd_len = '0; cmd_op = '0;
    hb_we = 1'b0; hb_addr = '0; hb_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready, "R1", "reset ready", cmd_ready, 1);
    chk(!req_valid, "R7", "reset req_valid", req_valid, 0);
    chk(!done_valid, "R9", "reset done", done_valid, 0);
    chk(cmd_id == 8'd0, "R8", "reset id", cmd_id, 0);

    fill(11);
    run_xfer(32'h1000, 64, 1'b1, 1'b1); wait_idle();
    run_xfer(32'h1010, 100, 1'b1, 1'b1); wait_idle();
    // R11: host write during a two-line store has no effect
    run_xfer(32'h5000, 128, 1'b1, 1'b1);
    hb_we = 1'b1; hb_addr = 8'd100; hb_wdata = 8'hEE;
    @(negedge clk);
    hb_we = 1'b0;
    wait_idle();
    hb_addr = 8'd100;
    @(negedge clk);
    chk(hb_rdata == g(100), "R11", "busy host write ignored", hb_rdata, g(100));

    bad_cmd(2'b11, 8);
    bad_cmd(2'b00, 8);
    bad_cmd(2'b01, 0);
    bad_cmd(2'b10, 257);

    run_xfer(32'h2038, 200, 1'b0, 1'b1); wait_idle(); check_load(32'h2038, 200);
    run_xfer(32'h3005, 3, 1'b0, 1'b1); wait_idle(); check_load(32'h3005, 3);
    run_xfer(32'h4020, 256, 1'b0, 1'b1); wait_idle(); check_load(32'h4020, 256);

    // R10: stray and wrong-kind responses with the memory model switched off
    auto_mem = 1'b0;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_is_data = 1'b0;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(rsp_err, "R10", "response while idle", rsp_err, 1);
    run_xfer(32'h6000, 4, 1'b1, 1'b0);
    while (!req_valid) @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_is_data = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(rsp_err, "R10", "data during store", rsp_err, 1);
    for (int i = 0; i < 3; i++) begin
      chk(!cmd_ready && !done_valid && !req_valid, "R10", "ignored response",
          {cmd_ready, done_valid, req_valid}, 0);
      @(negedge clk);
    end
    rsp_valid = 1'b1; rsp_is_data = 1'b0;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(done_valid, "R9", "ack completes", done_valid, 1);
    auto_mem = 1'b1;
    repeat (3) @(negedge clk);

    chk(exp_q.size() == 0, "R7", "all chunks issued", exp_q.size(), 0);
    chk(id_q.size() == 0, "R9", "all completions seen", id_q.size(), 0);
    summary();
    $finish;
  end
endmodule